// File: doc/BRIEF.md
# Transition-Compressed Sample Recorder

This block watches a parallel bus of digital channels and turns it into a compact stream of change events. The surrounding timebase supplies a one-cycle `sample_tick` strobe in the `clk` domain, and the block samples the bus on each strobe. While `arm` is high, a record is produced only when the sampled word differs from the last recorded word. Each record carries a free-running timestamp. From these records alone, the level of every channel at every sample point can be rebuilt, together with the tick on which each edge was seen.

Between strobes, every channel is also watched at full `clk` rate. A channel that moves more than once inside one sample window has its glitch bit set in the next record, so a pulse narrower than the sample period still leaves a mark. An optional qualifier gates storage, for example to store samples only while a select line is active. When the timestamp counter passes through zero, a record is emitted so that absolute time can be recovered.

Records leave on a valid/ready stream. A record that has been offered stays on `m_data`, unchanged, until it is accepted. When a new record falls due while the output is still held, the new record is dropped and a sticky overflow pin rises. Clearing `arm` clears that pin.

Top module: `edge_event_recorder`

## Requirements
- R1: After reset, `m_valid` and `overflow` are low.
- R2: On an armed, qualified tick, a record is emitted when the sampled word differs from the last recorded word, and no record is emitted when it does not. The record carries the sampled word and a stamp equal to the number of ticks since reset before this one, modulo 2^TSW_W.
- R3: The first qualified tick after `arm` rises is always recorded, with the sample bit set, even when the word equals the previous reference.
- R4: While `arm` is low, no records are emitted. The timestamp counter still advances on every tick.
- R5: When `qual_en` is 1 and `qual_in` is 0, a tick stores nothing and leaves the reference word unchanged. With `qual_en` at 0, every tick is qualified.
- R6: A channel that makes two or more transitions in one sample window gets its glitch bit set in the next emitted sample record, and that record is emitted even if the word is unchanged. A sample window runs from the cycle after one tick through the next tick cycle. A channel that makes exactly one transition gets no glitch bit. A glitch is reported in one record only.
- R7: An armed tick whose stamp is 0 emits a record with the wrap bit set. If no sample record is due on that tick, the sample bit is 0, the value field holds the last recorded word and the glitch field is 0. If a sample record is due, both bits are set.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays stable.
- R9: A record that falls due while the output is held is dropped, and `overflow` is set. `overflow` stays set until `arm` goes low. A dropped change does not update the reference, so it is reported on the next tick.
- R10: `m_data` layout: bits [TSW_W-1:0] stamp, next NCH bits value, next NCH bits glitch, then the sample bit, then the wrap bit at the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Recording enable; low clears the first-sample state and overflow |
| sample_tick | input | 1 | One-cycle sample strobe from the timebase |
| chan_in | input | NCH | Channel levels, synchronous to clk |
| qual_en | input | 1 | Use the qualifier |
| qual_in | input | 1 | Qualifier level; storage is allowed when high |
| m_valid | output | 1 | Record available |
| m_ready | input | 1 | Consumer accepts the record |
| m_data | output | 2*NCH+TSW_W+2 | Record, layout per R10 |
| overflow | output | 1 | Sticky: a record was dropped |

## Verification
A wrong reference word shows up at the ports on the very next qualified tick. Either a record appears for an unchanged word, or a change is missed and the following record carries a stale value. A glitch counter that is not cleared at the end of a window shows as glitch bits that repeat, or that appear after a single transition, in the next record. A stamp counter that is off by one is visible in the stamp field of the first record. Wrap handling only shows at the tick with stamp 0, so the bench walks the counter through two full turns.

// File: rtl/eer_pkg.sv
package eer_pkg;
  // Width of one record: wrap bit, sample bit, glitch field, value field, stamp.
  function automatic int rec_bits(input int nch, input int tsw);
    return 2 + 2 * nch + tsw;
  endfunction
endpackage

// File: rtl/eer_glitch_det.sv
module eer_glitch_det #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NCH-1:0] chan_in,
  output logic [NCH-1:0] multi_hit
);
  // One saturating transition counter per channel, restarted at every tick.
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic       last_q;
    logic [1:0] cnt_q;
    logic [1:0] total;
    logic       tg;

    assign tg = chan_in[g] ^ last_q;

    always_comb begin
      if (cnt_q == 2'd2) total = 2'd2;
      else               total = cnt_q + {1'b0, tg};
    end

    assign multi_hit[g] = (total == 2'd2);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        last_q <= 1'b0;
        cnt_q  <= 2'd0;
      end else begin
        last_q <= chan_in[g];
        cnt_q  <= tick ? 2'd0 : total;
      end
    end
  end
endmodule

// File: rtl/eer_stamp.sv
module eer_stamp #(
  parameter int TSW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [TSW_W-1:0] stamp,
  output logic             stamp_zero
);
  logic [TSW_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign stamp      = cnt_q;
  assign stamp_zero = (cnt_q == '0);
endmodule

// File: rtl/eer_change_ctl.sv
module eer_change_ctl #(
  parameter int NCH   = 8,
  parameter int TSW_W = 8,
  localparam int RW   = eer_pkg::rec_bits(NCH, TSW_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             tick,
  input  logic             qual_en,
  input  logic             qual_in,
  input  logic [NCH-1:0]   sample,
  input  logic [NCH-1:0]   multi_hit,
  input  logic [TSW_W-1:0] stamp,
  input  logic             stamp_zero,
  input  logic             slot_free,
  output logic             load,
  output logic [RW-1:0]    rec,
  output logic             overflow
);
  logic [NCH-1:0] ref_q;
  logic [NCH-1:0] pend_q;
  logic           first_q;
  logic           ovf_q;

  logic [NCH-1:0] gl_now;
  logic           qualified;
  logic           smp_need;
  logic           need;

  assign gl_now    = pend_q | multi_hit;
  assign qualified = !qual_en || qual_in;
  assign smp_need  = qualified && (first_q || (sample != ref_q) || (|gl_now));
  assign need      = tick && arm && (smp_need || stamp_zero);
  assign load      = need && slot_free;

  // Record assembly: {wrap, sample, glitch, value, stamp}.
  always_comb begin
    rec = {stamp_zero, smp_need,
           (smp_need ? gl_now : {NCH{1'b0}}),
           (smp_need ? sample : ref_q),
           stamp};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q   <= '0;
      pend_q  <= '0;
      first_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else if (!arm) begin
      pend_q  <= '0;
      first_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else if (tick) begin
      if (load && smp_need) begin
        ref_q   <= sample;
        first_q <= 1'b0;
        pend_q  <= '0;
      end else begin
        pend_q  <= gl_now;
      end
      if (need && !slot_free) ovf_q <= 1'b1;
    end
  end

  assign overflow = ovf_q;
endmodule

// File: rtl/eer_out_reg.sv
module eer_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         slot_free,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  assign slot_free = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= din;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_event_recorder.sv
module edge_event_recorder #(
  parameter int NCH   = 8,
  parameter int TSW_W = 8,
  localparam int RW   = eer_pkg::rec_bits(NCH, TSW_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic           sample_tick,
  input  logic [NCH-1:0] chan_in,
  input  logic           qual_en,
  input  logic           qual_in,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [RW-1:0]  m_data,
  output logic           overflow
);
  logic [NCH-1:0]   multi_hit;
  logic [TSW_W-1:0] stamp;
  logic             stamp_zero;
  logic             slot_free;
  logic             load;
  logic [RW-1:0]    rec;

  eer_glitch_det #(.NCH(NCH)) u_glitch (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick),
    .chan_in(chan_in), .multi_hit(multi_hit)
  );

  eer_stamp #(.TSW_W(TSW_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick),
    .stamp(stamp), .stamp_zero(stamp_zero)
  );

  eer_change_ctl #(.NCH(NCH), .TSW_W(TSW_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .tick(sample_tick),
    .qual_en(qual_en), .qual_in(qual_in), .sample(chan_in),
    .multi_hit(multi_hit), .stamp(stamp), .stamp_zero(stamp_zero),
    .slot_free(slot_free), .load(load), .rec(rec), .overflow(overflow)
  );

  eer_out_reg #(.W(RW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .din(rec),
    .slot_free(slot_free), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data)
  );
endmodule

// File: rtl/edge_event_recorder_chk.sv
module edge_event_recorder_chk #(
  parameter int NCH   = 8,
  parameter int TSW_W = 8,
  localparam int RW   = eer_pkg::rec_bits(NCH, TSW_W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          sample_tick,
  input logic          m_valid,
  input logic          m_ready,
  input logic [RW-1:0] m_data,
  input logic          overflow
);
  // R8: an offered record is held until accepted
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R4: a fresh record only follows an armed tick
  p_rec_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !$past(m_valid && !m_ready)) |-> $past(sample_tick && arm));

  // R9: overflow stays set while armed
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && arm) |=> overflow);

  // R9: overflow only rises while the output was held
  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(m_valid && !m_ready));

  // R7: every record is either a sample or a wrap marker
  p_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_data[RW-1] || m_data[RW-2]));
endmodule

bind edge_event_recorder edge_event_recorder_chk #(.NCH(NCH), .TSW_W(TSW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .sample_tick(sample_tick),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .overflow(overflow)
);

// File: tb/edge_event_recorder_tb.sv
`timescale 1ns/1ps
module edge_event_recorder_tb;
  localparam int NCH = 8;
  localparam int TW  = 8;
  localparam int RW  = 2 + 2 * NCH + TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic sample_tick = 1'b0;
  logic [NCH-1:0] chan_in = '0;
  logic qual_en = 1'b0;
  logic qual_in = 1'b0;
  logic m_ready = 1'b1;
  logic m_valid;
  logic [RW-1:0] m_data;
  logic overflow;

  int tests = 0;
  int fails = 0;
  int n_ticks = 0;
  logic [TW-1:0] last_stamp;
  logic got_v;
  logic [RW-1:0] got_d;

  always #2.5 clk = ~clk;

  edge_event_recorder #(.NCH(NCH), .TSW_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sample_tick(sample_tick),
    .chan_in(chan_in), .qual_en(qual_en), .qual_in(qual_in),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .overflow(overflow)
  );

  function automatic logic [RW-1:0] pack(input logic w, input logic s,
      input logic [NCH-1:0] g, input logic [NCH-1:0] v, input logic [TW-1:0] t);
    return {w, s, g, v, t};
  endfunction

  task automatic check(input string tag, input logic ok,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick(input logic [NCH-1:0] val);
    @(negedge clk);
    chan_in = val;
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    last_stamp = n_ticks[TW-1:0];
    n_ticks++;
    got_v = m_valid;
    got_d = m_data;
  endtask

  task automatic expect_rec(input string tag, input logic w, input logic s,
                            input logic [NCH-1:0] g, input logic [NCH-1:0] v);
    logic [RW-1:0] e;
    e = pack(w, s, g, v, last_stamp);
    check(tag, got_v === 1'b1 && got_d === e, {got_v, got_d}, {1'b1, e});
  endtask

  task automatic expect_none(input string tag);
    check(tag, got_v === 1'b0, got_v, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 valid after reset", m_valid === 1'b0, m_valid, 0);
    check("R1 overflow after reset", overflow === 1'b0, overflow, 0);
  endtask

  task automatic t_unarmed();
    do_tick(8'h11); expect_none("R4 unarmed tick 0");
    do_tick(8'h22); expect_none("R4 unarmed tick 1");
  endtask

  task automatic t_first();
    @(negedge clk); arm = 1'b1;
    do_tick(8'h22); expect_rec("R3 first armed sample, R4 stamp advanced", 0, 1, 0, 8'h22);
  endtask

  task automatic t_change();
    do_tick(8'h22); expect_none("R2 unchanged word");
    do_tick(8'h5A); expect_rec("R2 change 5A", 0, 1, 0, 8'h5A);
    do_tick(8'h5A); expect_none("R2 repeat 5A");
    do_tick(8'hA5); expect_rec("R2 R10 change A5", 0, 1, 0, 8'hA5);
  endtask

  task automatic t_qual();
    @(negedge clk); qual_en = 1'b1; qual_in = 1'b0;
    do_tick(8'h0F); expect_none("R5 blocked by qualifier");
    @(negedge clk); qual_in = 1'b1;
    do_tick(8'h0F); expect_rec("R5 reference kept", 0, 1, 0, 8'h0F);
    @(negedge clk); qual_en = 1'b0; qual_in = 1'b0;
    do_tick(8'h0E); expect_rec("R5 qualifier off", 0, 1, 0, 8'h0E);
  endtask

  task automatic t_glitch();
    do_tick(8'h0F); expect_rec("R6 single transition no glitch", 0, 1, 0, 8'h0F);
    @(negedge clk); chan_in = 8'h0B;
    @(negedge clk); chan_in = 8'h0F;
    do_tick(8'h0F); expect_rec("R6 pulse flagged, word unchanged", 0, 1, 8'h04, 8'h0F);
    do_tick(8'h0F); expect_none("R6 glitch reported once");
    @(negedge clk); chan_in = 8'h8F;
    @(negedge clk); chan_in = 8'h0F;
    do_tick(8'h8F); expect_rec("R6 three transitions", 0, 1, 8'h80, 8'h8F);
  endtask

  task automatic t_backpressure();
    @(negedge clk); m_ready = 1'b0;
    do_tick(8'h33); expect_rec("R8 record offered", 0, 1, 0, 8'h33);
    idle(3);
    check("R8 held valid", m_valid === 1'b1, m_valid, 1);
    check("R8 held data", m_data === got_d, m_data, got_d);
    do_tick(8'h44);
    check("R9 overflow set", overflow === 1'b1, overflow, 1);
    check("R9 R8 old record kept", got_d[NCH+TW-1:TW] === 8'h33, got_d[NCH+TW-1:TW], 8'h33);
    @(negedge clk); m_ready = 1'b1;
    @(negedge clk);
    check("R8 drained", m_valid === 1'b0, m_valid, 0);
    do_tick(8'h44); expect_rec("R9 dropped change re-reported", 0, 1, 0, 8'h44);
    check("R9 overflow sticky", overflow === 1'b1, overflow, 1);
    @(negedge clk); arm = 1'b0;
    @(negedge clk);
    check("R9 overflow cleared by disarm", overflow === 1'b0, overflow, 0);
    arm = 1'b1;
    do_tick(8'h44); expect_rec("R3 first after re-arm", 0, 1, 0, 8'h44);
  endtask

  task automatic t_wrap(input logic [NCH-1:0] at_zero, input logic smp_exp);
    int extra;
    extra = 0;
    while ((n_ticks % (1 << TW)) != 0) begin
      do_tick(8'h44);
      if (got_v) extra++;
    end
    check("R7 no records while idle to wrap", extra == 0, extra, 0);
    do_tick(at_zero);
    expect_rec("R7 R10 wrap record", 1, smp_exp, 0, at_zero);
    check("R10 wrap bit at MSB", got_d[RW-1] === 1'b1, got_d[RW-1], 1);
    if (smp_exp) do_tick(8'h44);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_first();
    t_change();
    t_qual();
    t_glitch();
    t_backpressure();
    t_wrap(8'h44, 1'b0);
    t_wrap(8'h66, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule